// File: doc/BRIEF.md
# Serial Command Receiver for a Multiplexed Display Controller

This block sits between a microcontroller's three-wire serial link and the storage of a multiplexed character display controller. The microcontroller holds an active-low select low, presents one data bit per shift-clock rising edge (least significant bit first) and sends bytes back to back. The block brings the three wires into the system clock domain, assembles bytes and decodes them. Each decoded byte becomes a single-cycle write strobe with address and data for one of three display RAMs, or a load of one of the display control registers.

The first byte after select falls is always a command. Its upper nibble chooses the operation and its lower nibble carries a start address or a parameter. After a RAM command, every further byte in the same select window is data for that RAM. The address moves forward on its own and wraps at the top. The pattern RAM takes two bytes per entry. The control registers (brightness, digit count, all-off and all-on flags) are held inside the block, and each has a load strobe.

Top module: `disp_cmd_rx`

## Requirements
- R1: Bits are taken only on shift-clock rising edges that occur while select is low, the first bit received being byte bit 0; shift-clock edges while select is high change nothing.
- R2: Byte boundaries are counted from the falling edge of select; bits of an incomplete byte are discarded when select rises.
- R3: The command is byte bits 7..4 read as a hex value: 0x1 character-code RAM, 0x2 pattern RAM, 0x3 symbol RAM, 0x5 brightness, 0x6 digit count, 0x7 display flags; bits 3..0 carry the address or value. At most one write or load strobe is high in any cycle.
- R4: After command 0x1 with address A, successive bytes are written whole to character-code RAM at A, A+1, ... wrapping from 0xF to 0x0.
- R5: After command 0x2 with address A, each pair of bytes forms one 16-bit pattern entry, the first byte giving bits 7..0 and the second bits 15..8; one write per pair, the address advancing by one per pair and wrapping.
- R6: After command 0x3 with address A, each byte writes its bits 1..0 to symbol RAM at the next address; bits 7..2 are ignored.
- R7: Command 0x5 loads bits 3..0 into the brightness register and command 0x6 loads them into the digit-count register; the other register keeps its value.
- R8: Command 0x7 sets the all-off flag from bit 0 and the all-on flag from bit 1; bits 3..2 have no effect.
- R9: While reset is low, brightness and digit count are 0, all-off is 1, all-on is 0, all RAM write pointers are 0 and no strobe is high.
- R10: Raising select ends a RAM data stream; the first byte after select falls again is decoded as a command.
- R11: Command nibbles 0x0, 0x4 and 0x8 to 0xF change no register and write no RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Serial select, active low, asynchronous |
| sck_i | input | 1 | Serial shift clock, asynchronous |
| sdi_i | input | 1 | Serial data, asynchronous |
| code_we_o | output | 1 | Character-code RAM write strobe |
| code_addr_o | output | 4 | Character-code RAM write address |
| code_data_o | output | 8 | Character-code RAM write data |
| pat_we_o | output | 1 | Pattern RAM write strobe |
| pat_addr_o | output | 4 | Pattern RAM write address |
| pat_data_o | output | 16 | Pattern RAM write data |
| sym_we_o | output | 1 | Symbol RAM write strobe |
| sym_addr_o | output | 4 | Symbol RAM write address |
| sym_data_o | output | 2 | Symbol RAM write data |
| bright_ld_o | output | 1 | Brightness load strobe |
| bright_o | output | 4 | Brightness register |
| digits_ld_o | output | 1 | Digit-count load strobe |
| digits_o | output | 4 | Digit-count register, 0 meaning all digits |
| flags_ld_o | output | 1 | Display-flag load strobe |
| all_off_o | output | 1 | All-off flag |
| all_on_o | output | 1 | All-on flag |

## Verification
The bench builds the block with its default parameters: 4-bit addresses, 8-bit bytes, 2-bit symbols and two synchronizer stages. At a 4-bit address width, a stream only three or four writes long starting at 0xE or 0xF crosses the wrap point, so wrap on every RAM is checked in a short run. Because the shift clock is slow relative to the system clock, the bench can observe partial bytes, select toggling between bytes, and shift-clock edges with select high.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;
  typedef enum logic [2:0] {
    M_CMD,
    M_CODE,
    M_PAT_LO,
    M_PAT_HI,
    M_SYM
  } rx_mode_e;

  localparam logic [3:0] OP_CODE   = 4'h1;
  localparam logic [3:0] OP_PAT    = 4'h2;
  localparam logic [3:0] OP_SYM    = 4'h3;
  localparam logic [3:0] OP_BRIGHT = 4'h5;
  localparam logic [3:0] OP_DIGITS = 4'h6;
  localparam logic [3:0] OP_FLAGS  = 4'h7;

  localparam int unsigned PARAM_W = 4;
endpackage

// File: rtl/disp_cmd_sync.sv
module disp_cmd_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/disp_cmd_shift.sv
module disp_cmd_shift #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic              sck_q;
  logic              sck_rise;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] shreg_nxt;

  assign sck_rise  = sck_i & ~sck_q;
  assign shreg_nxt = {sdi_i, shreg_q[BYTE_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q      <= 1'b0;
      bit_cnt_q  <= '0;
      shreg_q    <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      sck_q      <= sck_i;
      byte_vld_o <= 1'b0;
      if (cs_n_i) begin
        bit_cnt_q <= '0;
      end else if (sck_rise) begin
        shreg_q <= shreg_nxt;
        if (bit_cnt_q == CNT_W'(BYTE_W-1)) begin
          bit_cnt_q  <= '0;
          byte_vld_o <= 1'b1;
          byte_o     <= shreg_nxt;
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end
    end
  end

  AST_FRAME_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> (bit_cnt_q == '0)); // R2
  AST_NO_BYTE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> !byte_vld_o); // R1
endmodule

// File: rtl/disp_cmd_dec.sv
module disp_cmd_dec
  import disp_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SYM_W = 2,
  localparam int unsigned PAT_W = 2 * BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_n_i,
  input  logic               byte_vld_i,
  input  logic [BYTE_W-1:0]  byte_i,
  output logic               code_we_o,
  output logic [ADDR_W-1:0]  code_addr_o,
  output logic [BYTE_W-1:0]  code_data_o,
  output logic               pat_we_o,
  output logic [ADDR_W-1:0]  pat_addr_o,
  output logic [PAT_W-1:0]   pat_data_o,
  output logic               sym_we_o,
  output logic [ADDR_W-1:0]  sym_addr_o,
  output logic [SYM_W-1:0]   sym_data_o,
  output logic               bright_ld_o,
  output logic [PARAM_W-1:0] bright_o,
  output logic               digits_ld_o,
  output logic [PARAM_W-1:0] digits_o,
  output logic               flags_ld_o,
  output logic               all_off_o,
  output logic               all_on_o
);
  rx_mode_e          mode_q;
  logic [ADDR_W-1:0] code_ptr_q, pat_ptr_q, sym_ptr_q;
  logic [BYTE_W-1:0] pat_lo_q;
  logic [3:0]        op;
  logic [3:0]        arg;
  logic              op_known;

  assign op  = byte_i[BYTE_W-1 -: 4];
  assign arg = byte_i[3:0];
  assign op_known = (op == OP_CODE) || (op == OP_PAT) || (op == OP_SYM) ||
                    (op == OP_BRIGHT) || (op == OP_DIGITS) || (op == OP_FLAGS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= M_CMD;
      code_ptr_q  <= '0;
      pat_ptr_q   <= '0;
      sym_ptr_q   <= '0;
      pat_lo_q    <= '0;
      code_we_o   <= 1'b0;
      code_addr_o <= '0;
      code_data_o <= '0;
      pat_we_o    <= 1'b0;
      pat_addr_o  <= '0;
      pat_data_o  <= '0;
      sym_we_o    <= 1'b0;
      sym_addr_o  <= '0;
      sym_data_o  <= '0;
      bright_ld_o <= 1'b0;
      bright_o    <= '0;
      digits_ld_o <= 1'b0;
      digits_o    <= '0;
      flags_ld_o  <= 1'b0;
      all_off_o   <= 1'b1;
      all_on_o    <= 1'b0;
    end else begin
      code_we_o   <= 1'b0;
      pat_we_o    <= 1'b0;
      sym_we_o    <= 1'b0;
      bright_ld_o <= 1'b0;
      digits_ld_o <= 1'b0;
      flags_ld_o  <= 1'b0;
      if (byte_vld_i) begin
        case (mode_q)
          M_CMD: begin
            case (op)
              OP_CODE: begin
                code_ptr_q <= arg[ADDR_W-1:0];
                mode_q     <= M_CODE;
              end
              OP_PAT: begin
                pat_ptr_q <= arg[ADDR_W-1:0];
                mode_q    <= M_PAT_LO;
              end
              OP_SYM: begin
                sym_ptr_q <= arg[ADDR_W-1:0];
                mode_q    <= M_SYM;
              end
              OP_BRIGHT: begin
                bright_o    <= arg;
                bright_ld_o <= 1'b1;
              end
              OP_DIGITS: begin
                digits_o    <= arg;
                digits_ld_o <= 1'b1;
              end
              OP_FLAGS: begin
                all_off_o  <= arg[0];
                all_on_o   <= arg[1];
                flags_ld_o <= 1'b1;
              end
              default: ;
            endcase
          end
          M_CODE: begin
            code_we_o   <= 1'b1;
            code_addr_o <= code_ptr_q;
            code_data_o <= byte_i;
            code_ptr_q  <= code_ptr_q + 1'b1;
          end
          M_PAT_LO: begin
            pat_lo_q <= byte_i;
            mode_q   <= M_PAT_HI;
          end
          M_PAT_HI: begin
            pat_we_o   <= 1'b1;
            pat_addr_o <= pat_ptr_q;
            pat_data_o <= {byte_i, pat_lo_q};
            pat_ptr_q  <= pat_ptr_q + 1'b1;
            mode_q     <= M_PAT_LO;
          end
          M_SYM: begin
            sym_we_o   <= 1'b1;
            sym_addr_o <= sym_ptr_q;
            sym_data_o <= byte_i[SYM_W-1:0];
            sym_ptr_q  <= sym_ptr_q + 1'b1;
          end
          default: mode_q <= M_CMD;
        endcase
      end
      if (cs_n_i) mode_q <= M_CMD;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({code_we_o, pat_we_o, sym_we_o, bright_ld_o, digits_ld_o, flags_ld_o})); // R3
  AST_CODE_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_we_o |-> (code_ptr_q == ADDR_W'(code_addr_o + 1'b1))); // R4
  AST_PAT_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && mode_q == M_PAT_LO) |=> !pat_we_o); // R5
  AST_SYM_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_we_o |-> (sym_ptr_q == ADDR_W'(sym_addr_o + 1'b1))); // R6
  AST_DESELECT_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> (mode_q == M_CMD)); // R10
  AST_UNKNOWN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld_i && mode_q == M_CMD && !op_known) |=>
      !(code_we_o || pat_we_o || sym_we_o || bright_ld_o || digits_ld_o || flags_ld_o)); // R11
  AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bright_ld_o |-> $stable(bright_o)); // R7
endmodule

// File: rtl/disp_cmd_rx.sv
module disp_cmd_rx
  import disp_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned SYM_W = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PAT_W = 2 * BYTE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ni,
  input  logic               sck_i,
  input  logic               sdi_i,
  output logic               code_we_o,
  output logic [ADDR_W-1:0]  code_addr_o,
  output logic [BYTE_W-1:0]  code_data_o,
  output logic               pat_we_o,
  output logic [ADDR_W-1:0]  pat_addr_o,
  output logic [PAT_W-1:0]   pat_data_o,
  output logic               sym_we_o,
  output logic [ADDR_W-1:0]  sym_addr_o,
  output logic [SYM_W-1:0]   sym_data_o,
  output logic               bright_ld_o,
  output logic [PARAM_W-1:0] bright_o,
  output logic               digits_ld_o,
  output logic [PARAM_W-1:0] digits_o,
  output logic               flags_ld_o,
  output logic               all_off_o,
  output logic               all_on_o
);
  logic [2:0]        pins_s;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_d;

  disp_cmd_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, sdi_i}),
    .q_o   (pins_s)
  );

  disp_cmd_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_i    (pins_s[2]),
    .sck_i     (pins_s[1]),
    .sdi_i     (pins_s[0]),
    .byte_vld_o(byte_vld),
    .byte_o    (byte_d)
  );

  disp_cmd_dec #(
    .ADDR_W(ADDR_W),
    .BYTE_W(BYTE_W),
    .SYM_W (SYM_W)
  ) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_n_i     (pins_s[2]),
    .byte_vld_i (byte_vld),
    .byte_i     (byte_d),
    .code_we_o  (code_we_o),
    .code_addr_o(code_addr_o),
    .code_data_o(code_data_o),
    .pat_we_o   (pat_we_o),
    .pat_addr_o (pat_addr_o),
    .pat_data_o (pat_data_o),
    .sym_we_o   (sym_we_o),
    .sym_addr_o (sym_addr_o),
    .sym_data_o (sym_data_o),
    .bright_ld_o(bright_ld_o),
    .bright_o   (bright_o),
    .digits_ld_o(digits_ld_o),
    .digits_o   (digits_o),
    .flags_ld_o (flags_ld_o),
    .all_off_o  (all_off_o),
    .all_on_o   (all_on_o)
  );
endmodule

// File: tb/tb_disp_cmd_rx.sv
module tb_disp_cmd_rx;
  logic clk = 1'b0;
  logic rst_n, cs_n, sck, sdi;
  logic code_we, pat_we, sym_we, bright_ld, digits_ld, flags_ld, all_off, all_on;
  logic [3:0] code_addr, pat_addr, sym_addr, bright, digits;
  logic [7:0] code_data;
  logic [15:0] pat_data;
  logic [1:0] sym_data;

  int n_chk = 0, n_fail = 0;
  int code_n = 0, pat_n = 0, sym_n = 0;
  logic [3:0]  code_a [32];
  logic [7:0]  code_d [32];
  logic [3:0]  pat_a  [32];
  logic [15:0] pat_d  [32];
  logic [3:0]  sym_a  [32];
  logic [1:0]  sym_d  [32];

  always #4 clk = ~clk;

  disp_cmd_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .code_we_o(code_we), .code_addr_o(code_addr), .code_data_o(code_data),
    .pat_we_o(pat_we), .pat_addr_o(pat_addr), .pat_data_o(pat_data),
    .sym_we_o(sym_we), .sym_addr_o(sym_addr), .sym_data_o(sym_data),
    .bright_ld_o(bright_ld), .bright_o(bright), .digits_ld_o(digits_ld),
    .digits_o(digits), .flags_ld_o(flags_ld), .all_off_o(all_off), .all_on_o(all_on)
  );

  always @(negedge clk) begin
    if (code_we && code_n < 32) begin code_a[code_n] = code_addr; code_d[code_n] = code_data; code_n++; end
    if (pat_we && pat_n < 32) begin pat_a[pat_n] = pat_addr; pat_d[pat_n] = pat_data; pat_n++; end
    if (sym_we && sym_n < 32) begin sym_a[sym_n] = sym_addr; sym_d[sym_n] = sym_data; sym_n++; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 0; i < nbits; i++) begin
      sdi = b[i];
      wait_clk(3);
      sck = 1'b1;
      wait_clk(3);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic desel();
    wait_clk(8);
    cs_n = 1'b1;
    wait_clk(6);
  endtask

  task automatic frame1(input logic [7:0] b);
    sel();
    send_bits(b, 8);
    desel();
  endtask

  // {byte, brightness, digits, all_off, all_on} after the byte
  localparam logic [17:0] TBL [9] = '{
    {8'h5A, 4'hA, 4'h0, 1'b1, 1'b0},
    {8'h63, 4'hA, 4'h3, 1'b1, 1'b0},
    {8'h72, 4'hA, 4'h3, 1'b0, 1'b1},
    {8'h71, 4'hA, 4'h3, 1'b1, 1'b0},
    {8'h7C, 4'hA, 4'h3, 1'b0, 1'b0},
    {8'h4F, 4'hA, 4'h3, 1'b0, 1'b0},
    {8'hF5, 4'hA, 4'h3, 1'b0, 1'b0},
    {8'h50, 4'h0, 4'h3, 1'b0, 1'b0},
    {8'h6F, 4'h0, 4'hF, 1'b0, 1'b0}
  };

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    wait_clk(5);
    // R9: reset state
    chk({bright, digits, all_off, all_on} == 10'b0000_0000_10, "R9 reset regs",
        {bright, digits, all_off, all_on}, 10'b0000_0000_10);
    chk({code_we, pat_we, sym_we, bright_ld, digits_ld, flags_ld} == 6'b0, "R9 reset strobes",
        {code_we, pat_we, sym_we, bright_ld, digits_ld, flags_ld}, 0);
    rst_n = 1'b1;
    wait_clk(4);

    // R7 R8 R11: table of single-byte commands
    for (int k = 0; k < 9; k++) begin
      int w0;
      w0 = code_n + pat_n + sym_n;
      frame1(TBL[k][17:10]);
      chk({bright, digits, all_off, all_on} == TBL[k][9:0], "R7/R8/R11 table regs",
          {bright, digits, all_off, all_on}, TBL[k][9:0]);
      chk(code_n + pat_n + sym_n == w0, "R11 table no RAM write", code_n + pat_n + sym_n, w0);
    end

    // R4: character-code stream wrapping at 0xF
    sel();
    send_bits(8'h1E, 8); send_bits(8'h11, 8); send_bits(8'h22, 8); send_bits(8'h33, 8);
    desel();
    chk(code_n == 3, "R4 write count", code_n, 3);
    chk({code_a[0], code_d[0]} == 12'hE11, "R4 first", {code_a[0], code_d[0]}, 12'hE11);
    chk({code_a[1], code_d[1]} == 12'hF22, "R4 second", {code_a[1], code_d[1]}, 12'hF22);
    chk({code_a[2], code_d[2]} == 12'h033, "R4 wrap", {code_a[2], code_d[2]}, 12'h033);

    // R5: pattern pairs
    sel();
    send_bits(8'h2F, 8); send_bits(8'hA5, 8);
    wait_clk(8);
    chk(pat_n == 0, "R5 no write after low byte", pat_n, 0);
    send_bits(8'h3C, 8); send_bits(8'h12, 8); send_bits(8'h34, 8);
    desel();
    chk(pat_n == 2, "R5 write count", pat_n, 2);
    chk({pat_a[0], pat_d[0]} == 20'hF3CA5, "R5 first entry", {pat_a[0], pat_d[0]}, 20'hF3CA5);
    chk({pat_a[1], pat_d[1]} == 20'h03412, "R5 wrap entry", {pat_a[1], pat_d[1]}, 20'h03412);

    // R6: symbol bits
    sel();
    send_bits(8'h30, 8); send_bits(8'hFE, 8); send_bits(8'h01, 8);
    desel();
    chk(sym_n == 2, "R6 write count", sym_n, 2);
    chk({sym_a[0], sym_d[0]} == 6'b0000_10, "R6 first", {sym_a[0], sym_d[0]}, 6'b0000_10);
    chk({sym_a[1], sym_d[1]} == 6'b0001_01, "R6 second", {sym_a[1], sym_d[1]}, 6'b0001_01);

    // R10: deselect ends stream
    sel();
    send_bits(8'h15, 8); send_bits(8'h77, 8);
    desel();
    chk(code_n == 4 && code_a[3] == 4'h5 && code_d[3] == 8'h77, "R10 stream write",
        {code_a[3], code_d[3]}, 12'h577);
    frame1(8'h52);
    chk(code_n == 4, "R10 no data write after reselect", code_n, 4);
    chk(bright == 4'h2, "R10 byte decoded as command", bright, 2);

    // R1 R2: edges while deselected, then partial byte discarded
    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin wait_clk(3); sck = 1'b1; wait_clk(3); sck = 1'b0; end
    sel();
    send_bits(8'h07, 3);
    desel();
    chk(bright == 4'h2 && digits == 4'hF, "R1 deselected edges no effect",
        {bright, digits}, 8'h2F);
    frame1(8'h58);
    chk(bright == 4'h8, "R2 framing from select fall", bright, 8);

    // R9: reset mid-run
    rst_n = 1'b0;
    wait_clk(2);
    chk({bright, digits, all_off, all_on} == 10'b0000_0000_10, "R9 mid-run reset",
        {bright, digits, all_off, all_on}, 10'b0000_0000_10);
    rst_n = 1'b1;
    wait_clk(4);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule